// File: doc/BRIEF.md
# Buffer Descriptor Ring Sequencer

This block walks two rings of buffer descriptors kept in one local descriptor memory. Each descriptor holds two 32-bit words. Word 0 carries a 16-bit length in its upper half and control and status flags in its lower half. Word 1 is a buffer address. The transmit ring starts at entry 0. The receive ring starts at the entry whose index equals the programmed transmit count. The end of each ring is marked by a wrap flag in the descriptor itself.

For transmit, the sequencer fetches the current descriptor. When the descriptor is marked ready, it offers length, address and the pad and checksum options to a frame sender through a request/complete handshake. When the sender reports completion, the sequencer writes the status back into word 0, clears the ready flag, raises an event if the descriptor asks for one, and moves to the next entry. Receive works the same way on descriptors marked empty. It arms a buffer address for the frame receiver and writes back the received length and error flags. A frame that completes while no empty receive descriptor is armed is dropped and reported as a busy event.

Software reaches the descriptor memory through a simple synchronous host port. It addresses words as 2 × entry + word.

Top module: `bd_ring_seq`

## Requirements
- R1: After reset, `tx_req`, `rx_rdy` and all five event outputs are low, and both rings point at their first entry.
- R2: A host write with `host_we` high stores `host_wdata` at word address 2×entry+word (word 0 = flags/length, word 1 = buffer address). A host read presents that word on `host_rdata` one cycle after the request.
- R3: While transmit is enabled, a transmit descriptor with bit 15 (ready) set in word 0 is offered on `tx_req`, with `tx_len` = word0[31:16], `tx_addr` = word 1, `tx_pad` = bit 12 and `tx_crc` = bit 11. The offer holds until `tx_done`. A descriptor without bit 15 is polled and not offered.
- R4: On `tx_done`, word 0 is rewritten with the length and bits 14:9 kept, bit 15 cleared, and bits 8:0 set to `tx_stat`. The status layout is: bit 0 carrier lost, bit 1 deferred, bit 2 late collision, bit 3 retry limit, bits 7:4 retry count, bit 8 underrun.
- R5: A transmit write-back pulses `ev_txf` for one cycle when the status is zero and `ev_txe` when it is non-zero. Either pulse happens only if bit 14 (interrupt enable) of the descriptor is set.
- R6: After a descriptor with bit 13 (wrap) is written back, the ring continues at its first entry. Otherwise it continues at the next entry.
- R7: The first receive descriptor is entry `tx_count`, with the count limited to ENTRIES. A receive descriptor with bit 15 (empty) set raises `rx_rdy`, with `rx_addr` = word 1.
- R8: On `rx_done`, the armed receive descriptor's word 0 becomes {`rx_len`, 0, kept bits 14:9, `rx_stat`}. The length includes the 4 checksum bytes. The status layout is: bit 0 late collision, bit 1 checksum error, bit 2 short, bit 3 too long, bit 4 dribble nibble, bit 5 invalid symbol, bit 6 overrun, bit 7 miss, bit 8 control frame. The write-back pulses `ev_rxf` or `ev_rxe` under bit 14, by the same rule as R5.
- R9: `rx_done` while `rx_rdy` is low drops the frame, leaves the descriptor memory unchanged and pulses `ev_busy` one cycle later.
- R10: With a ring's enable low, that ring fetches nothing new and its pointer returns to its first entry, so re-enabling starts at the first entry. A descriptor already offered still completes.
- R11: `tx_done` while `tx_req` is low has no effect on memory or events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit ring enable |
| rx_en | input | 1 | Receive ring enable |
| tx_count | input | IW+1 | Number of transmit descriptors; also the first receive entry |
| host_en | input | 1 | Host access strobe |
| host_we | input | 1 | Host write select |
| host_addr | input | IW+1 | Host word address (2×entry+word) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, one cycle after the request |
| tx_req | output | 1 | Transmit descriptor offered to the sender |
| tx_len | output | 16 | Frame length of the offered descriptor |
| tx_addr | output | 32 | Buffer address of the offered descriptor |
| tx_pad | output | 1 | Pad option of the offered descriptor |
| tx_crc | output | 1 | Checksum option of the offered descriptor |
| tx_done | input | 1 | Sender completion pulse |
| tx_stat | input | 9 | Sender completion status |
| rx_rdy | output | 1 | Empty receive buffer armed |
| rx_addr | output | 32 | Address of the armed receive buffer |
| rx_done | input | 1 | Receiver completion pulse |
| rx_len | input | 16 | Received length including checksum |
| rx_stat | input | 9 | Receiver completion status |
| ev_txf | output | 1 | Transmit done without error |
| ev_txe | output | 1 | Transmit done with error |
| ev_rxf | output | 1 | Receive done without error |
| ev_rxe | output | 1 | Receive done with error |
| ev_busy | output | 1 | Received frame dropped, no buffer |

## Verification
The hardest case to reach is the dropped-frame case. It needs the receive pointer to have wrapped back onto a descriptor that software has not yet returned as empty. The stimulus fills both receive entries, completes both frames so that the wrap flag brings the pointer back to a descriptor now marked full, and then signals a frame. The stimulus also reaches the wrap-versus-next choice and the pointer reset on disable. It arms a decoy ready descriptor at the entry that a wrong pointer would land on, and checks which buffer address is offered.

// File: rtl/bdr_pkg.sv
package bdr_pkg;

  localparam int F_RDY  = 15;
  localparam int F_IRQ  = 14;
  localparam int F_WRAP = 13;
  localparam int F_PAD  = 12;
  localparam int F_CRC  = 11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_F0,
    ST_F1,
    ST_CHK,
    ST_WB
  } seq_st_t;

  // completion image of word 0: length, owner flag cleared, options kept, status
  function automatic logic [31:0] wb_word(input logic [31:0] w0,
                                          input logic [15:0] len,
                                          input logic [8:0]  stat);
    return {len, 1'b0, w0[14:9], stat};
  endfunction

endpackage

// File: rtl/bdr_desc_mem.sv
module bdr_desc_mem #(
  parameter int ENTRIES = 128,
  parameter int DW      = 32,
  localparam int WORDS  = 2 * ENTRIES,
  localparam int WAW    = $clog2(WORDS)
) (
  input  logic           clk,
  input  logic           a_en,
  input  logic           a_we,
  input  logic [WAW-1:0] a_addr,
  input  logic [DW-1:0]  a_wdata,
  output logic [DW-1:0]  a_rdata,
  input  logic           b_en,
  input  logic           b_we,
  input  logic [WAW-1:0] b_addr,
  input  logic [DW-1:0]  b_wdata,
  output logic [DW-1:0]  b_rdata
);

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (a_en && a_we) mem[a_addr] <= a_wdata;
    if (b_en && b_we) mem[b_addr] <= b_wdata;
    if (a_en) a_rdata <= mem[a_addr];
    if (b_en) b_rdata <= mem[b_addr];
  end

endmodule

// File: rtl/bdr_ring_ctx.sv
module bdr_ring_ctx #(
  parameter int IW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          load_v,
  input  logic [31:0]   load_w0,
  input  logic [31:0]   load_w1,
  input  logic          done_in,
  input  logic [15:0]   done_len,
  input  logic [8:0]    done_stat,
  input  logic          retire,
  output logic [IW-1:0] ptr,
  output logic          armed,
  output logic          pend,
  output logic [31:0]   w0,
  output logic [31:0]   w1,
  output logic [15:0]   p_len,
  output logic [8:0]    p_stat,
  output logic          drop
);
  import bdr_pkg::*;

  assign drop = done_in && !armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr    <= '0;
      armed  <= 1'b0;
      pend   <= 1'b0;
      w0     <= '0;
      w1     <= '0;
      p_len  <= '0;
      p_stat <= '0;
    end else begin
      if (load_v) begin
        armed <= 1'b1;
        w0    <= load_w0;
        w1    <= load_w1;
      end
      if (done_in && armed) begin
        armed  <= 1'b0;
        pend   <= 1'b1;
        p_len  <= done_len;
        p_stat <= done_stat;
      end
      if (retire) begin
        pend <= 1'b0;
        ptr  <= w0[F_WRAP] ? '0 : ptr + 1'b1;
      end else if (!en && !armed && !pend) begin
        ptr <= '0;
      end
    end
  end

  p_retire_pend_r4: assert property (@(posedge clk) disable iff (rst)
    retire |-> pend);

  p_arm_hold_r3: assert property (@(posedge clk) disable iff (rst)
    armed && !done_in |=> armed && $stable(w1));

  p_wrap_home_r6: assert property (@(posedge clk) disable iff (rst)
    retire && w0[F_WRAP] |=> ptr == '0);

  p_load_unarmed_r10: assert property (@(posedge clk) disable iff (rst)
    load_v |-> !armed && !pend);

endmodule

// File: rtl/bdr_seq_ctl.sv
module bdr_seq_ctl #(
  parameter int ENTRIES = 128,
  localparam int IW     = $clog2(ENTRIES),
  localparam int WAW    = IW + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tx_en,
  input  logic           rx_en,
  input  logic [IW:0]    tx_base,
  input  logic [IW-1:0]  tx_ptr,
  input  logic           tx_armed,
  input  logic           tx_pend,
  input  logic [31:0]    tx_w0,
  input  logic [8:0]     tx_pstat,
  input  logic [IW-1:0]  rx_ptr,
  input  logic           rx_armed,
  input  logic           rx_pend,
  input  logic [31:0]    rx_w0,
  input  logic [15:0]    rx_plen,
  input  logic [8:0]     rx_pstat,
  input  logic           rx_drop,
  output logic           b_en,
  output logic           b_we,
  output logic [WAW-1:0] b_addr,
  output logic [31:0]    b_wdata,
  input  logic [31:0]    b_rdata,
  output logic           tx_load,
  output logic           rx_load,
  output logic [31:0]    ld_w0,
  output logic [31:0]    ld_w1,
  output logic           tx_retire,
  output logic           rx_retire,
  output logic           ev_txf,
  output logic           ev_txe,
  output logic           ev_rxf,
  output logic           ev_rxe,
  output logic           ev_busy
);
  import bdr_pkg::*;

  seq_st_t     st;
  logic        sel_rx;
  logic        last_rx;
  logic [31:0] w0_cap;
  logic [IW:0] rx_sum;
  logic [IW-1:0] cur_entry;
  logic [31:0] cur_w0;
  logic [8:0]  cur_stat;
  logic        want_tx, want_rx;

  assign rx_sum    = tx_base + {1'b0, rx_ptr};
  assign cur_entry = sel_rx ? rx_sum[IW-1:0] : tx_ptr;
  assign cur_w0    = sel_rx ? rx_w0 : tx_w0;
  assign cur_stat  = sel_rx ? rx_pstat : tx_pstat;

  assign b_en    = (st == ST_F0) || (st == ST_F1) || (st == ST_WB);
  assign b_we    = (st == ST_WB);
  assign b_addr  = {cur_entry, (st == ST_F1)};
  assign b_wdata = sel_rx ? wb_word(rx_w0, rx_plen, rx_pstat)
                          : wb_word(tx_w0, tx_w0[31:16], tx_pstat);

  assign ld_w0   = w0_cap;
  assign ld_w1   = b_rdata;
  assign tx_load = (st == ST_CHK) && !sel_rx && w0_cap[F_RDY] && tx_en && !tx_armed;
  assign rx_load = (st == ST_CHK) &&  sel_rx && w0_cap[F_RDY] && rx_en && !rx_armed;
  assign tx_retire = (st == ST_WB) && !sel_rx;
  assign rx_retire = (st == ST_WB) &&  sel_rx;

  assign want_tx = tx_en && !tx_armed;
  assign want_rx = rx_en && !rx_armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      sel_rx  <= 1'b0;
      last_rx <= 1'b0;
      w0_cap  <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (tx_pend) begin
            sel_rx <= 1'b0;
            st     <= ST_WB;
          end else if (rx_pend) begin
            sel_rx <= 1'b1;
            st     <= ST_WB;
          end else if (want_tx && (!want_rx || last_rx)) begin
            sel_rx  <= 1'b0;
            last_rx <= 1'b0;
            st      <= ST_F0;
          end else if (want_rx) begin
            sel_rx  <= 1'b1;
            last_rx <= 1'b1;
            st      <= ST_F0;
          end
        end
        ST_F0:  st <= ST_F1;
        ST_F1: begin
          w0_cap <= b_rdata;
          st     <= ST_CHK;
        end
        ST_CHK: st <= ST_IDLE;
        ST_WB:  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_txf  <= 1'b0;
      ev_txe  <= 1'b0;
      ev_rxf  <= 1'b0;
      ev_rxe  <= 1'b0;
      ev_busy <= 1'b0;
    end else begin
      ev_txf  <= tx_retire && cur_w0[F_IRQ] && (cur_stat == '0);
      ev_txe  <= tx_retire && cur_w0[F_IRQ] && (cur_stat != '0);
      ev_rxf  <= rx_retire && cur_w0[F_IRQ] && (cur_stat == '0);
      ev_rxe  <= rx_retire && cur_w0[F_IRQ] && (cur_stat != '0);
      ev_busy <= rx_drop;
    end
  end

  p_wb_single_r4: assert property (@(posedge clk) disable iff (rst)
    st == ST_WB |=> st == ST_IDLE);

  p_ev_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ev_txf, ev_txe, ev_rxf, ev_rxe}));

  p_fetch_order_r3: assert property (@(posedge clk) disable iff (rst)
    st == ST_F0 |=> st == ST_F1);

endmodule

// File: rtl/bd_ring_seq.sv
module bd_ring_seq #(
  parameter int ENTRIES = 128,
  localparam int IW     = $clog2(ENTRIES),
  localparam int WAW    = IW + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tx_en,
  input  logic           rx_en,
  input  logic [IW:0]    tx_count,
  input  logic           host_en,
  input  logic           host_we,
  input  logic [WAW-1:0] host_addr,
  input  logic [31:0]    host_wdata,
  output logic [31:0]    host_rdata,
  output logic           tx_req,
  output logic [15:0]    tx_len,
  output logic [31:0]    tx_addr,
  output logic           tx_pad,
  output logic           tx_crc,
  input  logic           tx_done,
  input  logic [8:0]     tx_stat,
  output logic           rx_rdy,
  output logic [31:0]    rx_addr,
  input  logic           rx_done,
  input  logic [15:0]    rx_len,
  input  logic [8:0]     rx_stat,
  output logic           ev_txf,
  output logic           ev_txe,
  output logic           ev_rxf,
  output logic           ev_rxe,
  output logic           ev_busy
);
  import bdr_pkg::*;

  localparam logic [IW:0] MAX_TX = (IW+1)'(ENTRIES);

  logic [IW:0]    tx_base;
  logic           b_en, b_we;
  logic [WAW-1:0] b_addr;
  logic [31:0]    b_wdata, b_rdata;
  logic           tx_load, rx_load, tx_retire, rx_retire;
  logic [31:0]    ld_w0, ld_w1;
  logic [IW-1:0]  tx_ptr, rx_ptr;
  logic           tx_armed, tx_pend, rx_armed, rx_pend;
  logic [31:0]    tx_w0, tx_w1, rx_w0, rx_w1;
  logic [15:0]    tx_plen, rx_plen;
  logic [8:0]     tx_pstat, rx_pstat;
  logic           tx_drop, rx_drop;

  assign tx_base = (tx_count > MAX_TX) ? MAX_TX : tx_count;

  bdr_desc_mem #(.ENTRIES(ENTRIES), .DW(32)) u_mem (
    .clk(clk),
    .a_en(host_en), .a_we(host_we), .a_addr(host_addr),
    .a_wdata(host_wdata), .a_rdata(host_rdata),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr),
    .b_wdata(b_wdata), .b_rdata(b_rdata)
  );

  bdr_ring_ctx #(.IW(IW)) u_tx (
    .clk(clk), .rst(rst), .en(tx_en),
    .load_v(tx_load), .load_w0(ld_w0), .load_w1(ld_w1),
    .done_in(tx_done), .done_len(16'd0), .done_stat(tx_stat),
    .retire(tx_retire),
    .ptr(tx_ptr), .armed(tx_armed), .pend(tx_pend),
    .w0(tx_w0), .w1(tx_w1), .p_len(tx_plen), .p_stat(tx_pstat),
    .drop(tx_drop)
  );

  bdr_ring_ctx #(.IW(IW)) u_rx (
    .clk(clk), .rst(rst), .en(rx_en),
    .load_v(rx_load), .load_w0(ld_w0), .load_w1(ld_w1),
    .done_in(rx_done), .done_len(rx_len), .done_stat(rx_stat),
    .retire(rx_retire),
    .ptr(rx_ptr), .armed(rx_armed), .pend(rx_pend),
    .w0(rx_w0), .w1(rx_w1), .p_len(rx_plen), .p_stat(rx_pstat),
    .drop(rx_drop)
  );

  bdr_seq_ctl #(.ENTRIES(ENTRIES)) u_ctl (
    .clk(clk), .rst(rst), .tx_en(tx_en), .rx_en(rx_en), .tx_base(tx_base),
    .tx_ptr(tx_ptr), .tx_armed(tx_armed), .tx_pend(tx_pend),
    .tx_w0(tx_w0), .tx_pstat(tx_pstat),
    .rx_ptr(rx_ptr), .rx_armed(rx_armed), .rx_pend(rx_pend),
    .rx_w0(rx_w0), .rx_plen(rx_plen), .rx_pstat(rx_pstat), .rx_drop(rx_drop),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata),
    .tx_load(tx_load), .rx_load(rx_load), .ld_w0(ld_w0), .ld_w1(ld_w1),
    .tx_retire(tx_retire), .rx_retire(rx_retire),
    .ev_txf(ev_txf), .ev_txe(ev_txe), .ev_rxf(ev_rxf), .ev_rxe(ev_rxe),
    .ev_busy(ev_busy)
  );

  assign tx_req  = tx_armed;
  assign tx_len  = tx_w0[31:16];
  assign tx_addr = tx_w1;
  assign tx_pad  = tx_w0[F_PAD];
  assign tx_crc  = tx_w0[F_CRC];
  assign rx_rdy  = rx_armed;
  assign rx_addr = rx_w1;

  // sink for unused context fields (transmit length comes from the descriptor)
  logic unused_ok;
  assign unused_ok = ^{tx_plen, rx_w0[31:16], tx_drop};

  p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
    tx_req && !tx_done |=> tx_req);

  p_busy_cause_r9: assert property (@(posedge clk) disable iff (rst)
    ev_busy |-> $past(rx_done));

  p_busy_armed_r9: assert property (@(posedge clk) disable iff (rst)
    rx_done && rx_rdy |=> !ev_busy);

  p_ignore_done_r11: assert property (@(posedge clk) disable iff (rst)
    tx_done && !tx_req |=> !tx_req || $past(tx_load));

endmodule

// File: tb/bd_ring_seq_tb_top.sv
module bd_ring_seq_tb_top;

  localparam int ENTRIES = 128;
  localparam int IW      = $clog2(ENTRIES);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic           tx_en = 0, rx_en = 0;
  logic [IW:0]    tx_count = 4;
  logic           host_en = 0, host_we = 0;
  logic [IW:0]    host_addr = '0;
  logic [31:0]    host_wdata = '0, host_rdata;
  logic           tx_req, tx_pad, tx_crc, rx_rdy;
  logic [15:0]    tx_len;
  logic [31:0]    tx_addr, rx_addr;
  logic           tx_done = 0, rx_done = 0;
  logic [8:0]     tx_stat = '0, rx_stat = '0;
  logic [15:0]    rx_len = '0;
  logic           ev_txf, ev_txe, ev_rxf, ev_rxe, ev_busy;

  bd_ring_seq #(.ENTRIES(ENTRIES)) dut_i (
    .clk(clk), .rst(rst), .tx_en(tx_en), .rx_en(rx_en), .tx_count(tx_count),
    .host_en(host_en), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tx_req(tx_req), .tx_len(tx_len), .tx_addr(tx_addr), .tx_pad(tx_pad),
    .tx_crc(tx_crc), .tx_done(tx_done), .tx_stat(tx_stat),
    .rx_rdy(rx_rdy), .rx_addr(rx_addr), .rx_done(rx_done), .rx_len(rx_len),
    .rx_stat(rx_stat), .ev_txf(ev_txf), .ev_txe(ev_txe), .ev_rxf(ev_rxf),
    .ev_rxe(ev_rxe), .ev_busy(ev_busy)
  );

  int checks = 0;
  int errors = 0;
  logic [4:0] exp_q[$];   // {busy, rxe, rxf, txe, txf}

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && (ev_txf | ev_txe | ev_rxf | ev_rxe | ev_busy)) begin
      logic [4:0] got;
      got = {ev_busy, ev_rxe, ev_rxf, ev_txe, ev_txf};
      if (exp_q.size() == 0) chk(0, "R5/R8/R9/R11 unexpected event", 32'(got), 32'h0);
      else begin
        logic [4:0] e;
        e = exp_q.pop_front();
        chk(got == e, "R5/R8/R9 event", 32'(got), 32'(e));
      end
    end
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic hwr(input int entry, input int word, input logic [31:0] d);
    @(negedge clk);
    host_en = 1; host_we = 1; host_addr = (IW+1)'(2*entry + word); host_wdata = d;
    @(negedge clk);
    host_en = 0; host_we = 0;
  endtask

  task automatic hrd(input int entry, input int word, output logic [31:0] d);
    @(negedge clk);
    host_en = 1; host_we = 0; host_addr = (IW+1)'(2*entry + word);
    @(negedge clk);
    host_en = 0;
    d = host_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_tx(input string tag);
    int n = 0;
    while (!tx_req && n < 300) begin @(negedge clk); n++; end
    chk(tx_req, tag, 32'(tx_req), 32'h1);
  endtask

  task automatic wait_rx(input string tag);
    int n = 0;
    while (!rx_rdy && n < 300) begin @(negedge clk); n++; end
    chk(rx_rdy, tag, 32'(rx_rdy), 32'h1);
  endtask

  task automatic tx_finish(input logic [8:0] st, input logic [4:0] ev, input bit has_ev);
    if (has_ev) exp_q.push_back(ev);
    @(negedge clk);
    tx_done = 1; tx_stat = st;
    @(negedge clk);
    tx_done = 0; tx_stat = '0;
    idle(6);
  endtask

  task automatic rx_finish(input logic [15:0] len, input logic [8:0] st,
                           input logic [4:0] ev, input bit has_ev);
    if (has_ev) exp_q.push_back(ev);
    @(negedge clk);
    rx_done = 1; rx_len = len; rx_stat = st;
    @(negedge clk);
    rx_done = 0; rx_stat = '0;
    idle(6);
  endtask

  logic [31:0] rd;

  initial begin
    idle(3);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(!tx_req, "R1 tx_req", 32'(tx_req), 0);
    chk(!rx_rdy, "R1 rx_rdy", 32'(rx_rdy), 0);
    chk({ev_txf, ev_txe, ev_rxf, ev_rxe, ev_busy} == 0, "R1 events",
        32'({ev_txf, ev_txe, ev_rxf, ev_rxe, ev_busy}), 0);

    // R2 host port
    hwr(3, 1, 32'hCAFE_0003);
    hrd(3, 1, rd);
    chk(rd == 32'hCAFE_0003, "R2 host readback", rd, 32'hCAFE_0003);

    // transmit descriptors: word 1 first, then word 0
    hwr(0, 1, 32'h0000_1000); hwr(0, 0, 32'h0040_C800);   // ready, irq, crc, len 64
    hwr(1, 1, 32'h0000_2000); hwr(1, 0, 32'h003C_F000);   // ready, irq, wrap, pad, len 60
    hwr(2, 1, 32'h0000_9000); hwr(2, 0, 32'h0010_8000);   // decoy beyond wrap
    tx_en = 1;
    wait_tx("R3 first offer");
    chk(tx_len == 16'd64 && tx_addr == 32'h1000, "R3 len/addr e0",
        {tx_len, tx_addr[15:0]}, {16'd64, 16'h1000});
    chk(tx_crc && !tx_pad, "R3 options e0", 32'({tx_pad, tx_crc}), 32'b01);
    tx_finish(9'h000, 5'b00001, 1);
    wait_tx("R3 second offer");
    chk(tx_len == 16'd60 && tx_addr == 32'h2000 && tx_pad, "R3 len/addr/pad e1",
        {tx_len, tx_addr[15:0]}, {16'd60, 16'h2000});
    tx_finish(9'h035, 5'b00010, 1);
    hrd(0, 0, rd);
    chk(rd == 32'h0040_4800, "R4 writeback e0", rd, 32'h0040_4800);
    hrd(1, 0, rd);
    chk(rd == 32'h003C_7035, "R4 writeback e1 status", rd, 32'h003C_7035);

    // R6 wrap: entry 0 must be next, not entry 2
    hwr(0, 1, 32'h0000_3000); hwr(0, 0, 32'h0020_8000);   // ready, no irq
    wait_tx("R6 offer after wrap");
    chk(tx_addr == 32'h3000, "R6 wrap to first entry", tx_addr, 32'h3000);
    tx_finish(9'h000, 5'b0, 0);                            // R5 no irq, no event

    // R11 stray completion while nothing offered
    chk(!tx_req, "R11 no offer", 32'(tx_req), 0);
    tx_finish(9'h1FF, 5'b0, 0);
    hrd(1, 0, rd);
    chk(rd == 32'h003C_7035, "R11 memory untouched", rd, 32'h003C_7035);

    // R10 disable returns pointer home
    tx_en = 0;
    idle(10);
    hwr(1, 1, 32'h0000_5000); hwr(1, 0, 32'h0008_8000);
    hwr(0, 1, 32'h0000_4000); hwr(0, 0, 32'h0008_8000);
    idle(20);
    chk(!tx_req, "R10 no fetch while disabled", 32'(tx_req), 0);
    tx_en = 1;
    wait_tx("R10 offer after enable");
    chk(tx_addr == 32'h4000, "R10 restart at first entry", tx_addr, 32'h4000);
    tx_finish(9'h000, 5'b0, 0);
    tx_en = 0;
    idle(10);

    // receive ring starts at entry tx_count = 4
    hwr(4, 1, 32'h0000_8000); hwr(4, 0, 32'h0000_C000);   // empty, irq
    hwr(5, 1, 32'h0000_8800); hwr(5, 0, 32'h0000_E000);   // empty, irq, wrap
    rx_en = 1;
    wait_rx("R7 arm");
    chk(rx_addr == 32'h8000, "R7 first receive entry", rx_addr, 32'h8000);
    rx_finish(16'd68, 9'h000, 5'b00100, 1);
    hrd(4, 0, rd);
    chk(rd == 32'h0044_4000, "R8 writeback e4", rd, 32'h0044_4000);
    wait_rx("R8 arm e5");
    chk(rx_addr == 32'h8800, "R8 next entry", rx_addr, 32'h8800);
    rx_finish(16'd100, 9'h002, 5'b01000, 1);
    hrd(5, 0, rd);
    chk(rd == 32'h0064_6002, "R8 writeback e5 error", rd, 32'h0064_6002);

    // R9 wrapped onto full e4: drop
    idle(10);
    chk(!rx_rdy, "R9 nothing armed", 32'(rx_rdy), 0);
    rx_finish(16'd80, 9'h000, 5'b10000, 1);
    hrd(4, 0, rd);
    chk(rd == 32'h0044_4000, "R9 memory untouched", rd, 32'h0044_4000);

    // R7/R10 new split after disable
    rx_en = 0;
    tx_count = 6;
    idle(10);
    hwr(6, 1, 32'h0000_A000); hwr(6, 0, 32'h0000_A000);   // empty, wrap, no irq
    rx_en = 1;
    wait_rx("R7 arm at new base");
    chk(rx_addr == 32'hA000, "R7 base follows tx_count", rx_addr, 32'hA000);
    rx_finish(16'd64, 9'h000, 5'b0, 0);
    hrd(6, 0, rd);
    chk(rd == 32'h0040_2000, "R8 writeback e6", rd, 32'h0040_2000);

    idle(5);
    chk(exp_q.size() == 0, "R5/R8 expected events seen", 32'(exp_q.size()), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule